// File: doc/BRIEF.md
# Key Derivation Stage Controller

This block sequences a key derivation engine through a fixed chain of stages, from the power-up stage to a terminal disabled stage. Software selects one of three operations (advance to the next stage, generate an identity, or generate a software output) on a three-bit enable field and pulses a start strobe. The block judges the request against the current stage, the requested and maximum key versions, and the input data pattern. It then holds the one-hot command towards an external hash engine until that engine reports completion.

Each operation ends with a one-cycle completion pulse, a status code and an error code. A failed operation also raises an error interrupt and a recoverable alert. A life-cycle disable or a direct disable request ends the key chain at once. Illegal or unstable command encodings, and completion strobes that arrive when no operation is running, are treated as fatal. After a fatal event the block parks in an invalid stage, and every later operation fails. A write-enable for the software-binding registers closes after every successful advance, and software reopens it.

Top module: `kdf_stage_ctrl`

## Requirements
- R1: After reset, `stage` is 0 (reset stage), `status` is 0 (idle), `err_code` is 0, `cfg_wen` and `bind_wen` are 1, and `hash_cmd`, `alert_fatal`, `fault_cmd`, `fault_done` and `op_done` are 0.
- R2: Stage codes are 0 reset, 1 creator root, 2 owner intermediate, 3 owner root, 4 disabled, 5 invalid. A successful advance (`op_en` bit 0) moves the stage up by one in the edge that completes it, and from stage 3 it moves to 4. An advance in stage 4 or 5 fails with error code 1.
- R3: A generate operation (`op_en` bit 1 identity, bit 2 software output) is legal only in stages 1 to 3. In any other stage it ends with error code 1 (invalid operation), `sw_out_we` stays 0 and `hash_key_ok` is 0 during the run.
- R4: A legal generate with `key_ver` greater than `max_ver` ends with error code 2 (bad input). The stage does not change and `hash_key_ok` is 0 throughout the run.
- R5: A legal operation whose `in_data` is all zeros or all ones ends with error code 3 (bad data), and `sw_out_we` stays 0. Stage legality outranks the version check, which outranks the data check.
- R6: Every completion gives `op_done` high for exactly one cycle. `status` then reads 2 on success or 3 on failure. `err_irq` and `alert_recov` pulse in the same cycle only on failure, and `sw_out_we` pulses only on a successful software-output generation.
- R7: While an operation runs, `status` is 1, `cfg_wen` is 0, `hash_cmd` equals the launched one-hot enable, and a further start is ignored. When idle, `hash_cmd` is 0.
- R8: `bind_wen` drops to 0 in the edge that completes a successful advance, and it returns to 1 the edge after `bind_unlock` is sampled high.
- R9: `lc_disable` or `dis_req` moves the stage to 4 in the next edge, from any stage other than 5. `hash_key_ok` drops in the same cycle, and an operation already running ends with error code 1.
- R10: A start with more than one `op_en` bit set, or a change of `op_en` while an operation runs, sets `fault_cmd` and `alert_fatal` and moves the stage to 5. Both flags stay set until reset.
- R11: `hash_done` while no operation runs sets `fault_done` and `alert_fatal` and moves the stage to 5.
- R12: In stage 5 the stage never changes, and every operation ends with status 3 and error code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe for the operation selected by `op_en` |
| op_en | input | 3 | Operation enables: bit 0 advance, bit 1 identity, bit 2 software output |
| key_ver | input | VER_W | Requested key version |
| max_ver | input | VER_W | Maximum key version allowed in the current stage |
| in_data | input | DATA_W | Input data fed to the derivation |
| lc_disable | input | 1 | Life-cycle disable |
| dis_req | input | 1 | Direct disable request from software |
| bind_unlock | input | 1 | Reopens the software-binding write enable |
| hash_done | input | 1 | Completion strobe from the hash engine |
| hash_cmd | output | 3 | One-hot command towards the hash engine |
| hash_key_ok | output | 1 | Key towards the hash engine is valid |
| stage | output | 3 | Current stage code |
| status | output | 2 | 0 idle, 1 running, 2 done ok, 3 done with error |
| err_code | output | 2 | Error code of the last completion |
| op_done | output | 1 | Completion interrupt pulse |
| err_irq | output | 1 | Error interrupt pulse |
| alert_recov | output | 1 | Recoverable alert pulse |
| alert_fatal | output | 1 | Fatal alert, sticky until reset |
| fault_cmd | output | 1 | Command encoding fault flag |
| fault_done | output | 1 | Stray completion fault flag |
| cfg_wen | output | 1 | Configuration write enable, low while running |
| bind_wen | output | 1 | Software-binding write enable |
| sw_out_we | output | 1 | Software output update strobe |

## Verification
A wrong stage register appears at `stage` in the edge after the advance or disable event. It also changes the legality verdict of the next operation, so the next `err_code` and `status` come out wrong. A latched error lost or gained during a run shows within the run on `hash_key_ok`, and at completion on `err_irq`, `status` and `sw_out_we`. A missed fatal detection leaves `alert_fatal` low one edge after the offending input, and it lets later operations succeed where they must fail.

// File: rtl/kdf_pkg.sv
// Shared types and codes for the key derivation stage controller.
// Assumes: stage codes are ordered so that "advance" is an increment
// from the reset stage up to the owner root stage.
package kdf_pkg;

    typedef enum logic [2:0] {
        STG_RESET    = 3'd0,
        STG_CREATOR  = 3'd1,
        STG_OWN_INT  = 3'd2,
        STG_OWN_ROOT = 3'd3,
        STG_DISABLED = 3'd4,
        STG_INVALID  = 3'd5
    } stage_e;

    localparam logic [1:0] RUN_IDLE = 2'd0;
    localparam logic [1:0] RUN_WIP  = 2'd1;
    localparam logic [1:0] RUN_OK   = 2'd2;
    localparam logic [1:0] RUN_ERR  = 2'd3;

    localparam logic [1:0] ERR_NONE  = 2'd0;
    localparam logic [1:0] ERR_OP    = 2'd1;
    localparam logic [1:0] ERR_INPUT = 2'd2;
    localparam logic [1:0] ERR_DATA  = 2'd3;

    localparam int OP_W    = 3;
    localparam int OP_ADV  = 0;
    localparam int OP_ID   = 1;
    localparam int OP_SW   = 2;

endpackage

// File: rtl/kdf_cmd_check.sv
// Combinational legality check of a requested operation.
// Assumes: op_en is one-hot when the result is used; the ordering of
// checks is stage legality, then version, then data pattern.
module kdf_cmd_check
    import kdf_pkg::*;
#(
    parameter int VER_W  = 16,
    parameter int DATA_W = 32
) (
    input  stage_e              stage,
    input  logic [OP_W-1:0]     op_en,
    input  logic [VER_W-1:0]    key_ver,
    input  logic [VER_W-1:0]    max_ver,
    input  logic [DATA_W-1:0]   in_data,
    output logic [1:0]          code
);

    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    logic is_adv;
    logic is_gen;
    logic stage_ok;

    // Classify the operation and grade it against stage, version and data.
    always_comb begin
        is_adv   = op_en[OP_ADV];
        is_gen   = op_en[OP_ID] | op_en[OP_SW];
        stage_ok = is_adv ? (stage <= STG_OWN_ROOT)
                          : (stage >= STG_CREATOR && stage <= STG_OWN_ROOT);
        code = ERR_NONE;
        if (!stage_ok)
            code = ERR_OP;
        else if (is_gen && (key_ver > max_ver))
            code = ERR_INPUT;
        else if (in_data == '0 || in_data == ALL_ONES)
            code = ERR_DATA;
    end

endmodule

// File: rtl/kdf_op_seq.sv
// Operation sequencer: launches a command, holds it towards the hash
// engine until completion, tracks the error of the run and detects
// command and completion faults.
// Assumes: software keeps op_en stable for the whole run.
module kdf_op_seq
    import kdf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [OP_W-1:0] op_en,
    input  logic [1:0]      chk_code,
    input  logic            dis_evt,
    input  logic            hash_done,
    output logic            busy,
    output logic [OP_W-1:0] cmd_q,
    output logic            key_ok,
    output logic [1:0]      status,
    output logic [1:0]      err_code,
    output logic            op_done,
    output logic            err_pulse,
    output logic            sw_we,
    output logic            adv_ok,
    output logic            fatal_evt,
    output logic            fault_cmd,
    output logic            fault_done
);

    logic [1:0] err_q;
    logic [1:0] err_live;
    logic       onehot_ok;
    logic       launch;
    logic       bad_sel;
    logic       cmd_flip;
    logic       stray_done;
    logic       finish;
    logic       sw_ok;

    // Decode launch, completion and the three fault conditions.
    always_comb begin
        onehot_ok  = (op_en & (op_en - 3'd1)) == '0;
        launch     = !busy && start && (op_en != '0) && onehot_ok;
        bad_sel    = !busy && start && !onehot_ok;
        cmd_flip   = busy && (op_en != cmd_q);
        stray_done = !busy && hash_done;
        finish     = busy && hash_done;
        fatal_evt  = bad_sel || cmd_flip || stray_done;
        err_live   = (err_q == ERR_NONE && (dis_evt || cmd_flip)) ? ERR_OP : err_q;
        adv_ok     = finish && (err_live == ERR_NONE) && cmd_q[OP_ADV];
        sw_ok      = finish && (err_live == ERR_NONE) && cmd_q[OP_SW];
        key_ok     = busy && (err_live == ERR_NONE);
    end

    // Run state, latched error, completion pulses and sticky fault flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            cmd_q      <= '0;
            err_q      <= ERR_NONE;
            status     <= RUN_IDLE;
            err_code   <= ERR_NONE;
            op_done    <= 1'b0;
            err_pulse  <= 1'b0;
            sw_we      <= 1'b0;
            fault_cmd  <= 1'b0;
            fault_done <= 1'b0;
        end else begin
            op_done   <= finish;
            err_pulse <= finish && (err_live != ERR_NONE);
            sw_we     <= sw_ok;
            if (launch) begin
                busy   <= 1'b1;
                cmd_q  <= op_en;
                err_q  <= dis_evt ? ERR_OP : chk_code;
                status <= RUN_WIP;
            end else if (finish) begin
                busy     <= 1'b0;
                cmd_q    <= '0;
                err_q    <= ERR_NONE;
                err_code <= err_live;
                status   <= (err_live == ERR_NONE) ? RUN_OK : RUN_ERR;
            end else if (busy) begin
                err_q <= err_live;
            end
            if (bad_sel || cmd_flip) fault_cmd  <= 1'b1;
            if (stray_done)          fault_done <= 1'b1;
        end
    end

endmodule

// File: rtl/kdf_stage_reg.sv
// Stage register and software-binding write enable.
// Assumes: fatal events outrank disable, which outranks advance; the
// invalid stage is left only through reset.
module kdf_stage_reg
    import kdf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fatal_evt,
    input  logic   dis_evt,
    input  logic   adv_ok,
    input  logic   bind_unlock,
    output stage_e stage,
    output logic   bind_wen
);

    // Stage update with fatal > disable > advance priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage <= STG_RESET;
        else if (fatal_evt)
            stage <= STG_INVALID;
        else if (stage == STG_INVALID)
            stage <= STG_INVALID;
        else if (dis_evt)
            stage <= STG_DISABLED;
        else if (adv_ok)
            stage <= (stage == STG_OWN_ROOT) ? STG_DISABLED : stage_e'(stage + 3'd1);
    end

    // Binding write enable: closed by a successful advance, reopened by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bind_wen <= 1'b1;
        else if (adv_ok)
            bind_wen <= 1'b0;
        else if (bind_unlock)
            bind_wen <= 1'b1;
    end

endmodule

// File: rtl/kdf_stage_ctrl.sv
// Top of the key derivation stage controller: joins the legality check,
// the operation sequencer and the stage register.
// Assumes: all inputs are synchronous to clk.
module kdf_stage_ctrl
    import kdf_pkg::*;
#(
    parameter int VER_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op_en,
    input  logic [VER_W-1:0]  key_ver,
    input  logic [VER_W-1:0]  max_ver,
    input  logic [DATA_W-1:0] in_data,
    input  logic              lc_disable,
    input  logic              dis_req,
    input  logic              bind_unlock,
    input  logic              hash_done,
    output logic [2:0]        hash_cmd,
    output logic              hash_key_ok,
    output logic [2:0]        stage,
    output logic [1:0]        status,
    output logic [1:0]        err_code,
    output logic              op_done,
    output logic              err_irq,
    output logic              alert_recov,
    output logic              alert_fatal,
    output logic              fault_cmd,
    output logic              fault_done,
    output logic              cfg_wen,
    output logic              bind_wen,
    output logic              sw_out_we
);

    stage_e     stage_q;
    logic [1:0] chk_code;
    logic       dis_evt;
    logic       busy;
    logic       err_pulse;
    logic       adv_ok;
    logic       fatal_evt;

    // Either disable source ends the key chain.
    assign dis_evt = lc_disable | dis_req;

    kdf_cmd_check #(.VER_W(VER_W), .DATA_W(DATA_W)) u_check (
        .stage   (stage_q),
        .op_en   (op_en),
        .key_ver (key_ver),
        .max_ver (max_ver),
        .in_data (in_data),
        .code    (chk_code)
    );

    kdf_op_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op_en      (op_en),
        .chk_code   (chk_code),
        .dis_evt    (dis_evt),
        .hash_done  (hash_done),
        .busy       (busy),
        .cmd_q      (hash_cmd),
        .key_ok     (hash_key_ok),
        .status     (status),
        .err_code   (err_code),
        .op_done    (op_done),
        .err_pulse  (err_pulse),
        .sw_we      (sw_out_we),
        .adv_ok     (adv_ok),
        .fatal_evt  (fatal_evt),
        .fault_cmd  (fault_cmd),
        .fault_done (fault_done)
    );

    kdf_stage_reg u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .fatal_evt   (fatal_evt),
        .dis_evt     (dis_evt),
        .adv_ok      (adv_ok),
        .bind_unlock (bind_unlock),
        .stage       (stage_q),
        .bind_wen    (bind_wen)
    );

    // Port-level views of internal state.
    assign stage       = stage_q;
    assign cfg_wen     = !busy;
    assign err_irq     = err_pulse;
    assign alert_recov = err_pulse;
    assign alert_fatal = fault_cmd | fault_done;

endmodule

// File: rtl/kdf_stage_ctrl_chk.sv
// Checker for the stage controller, bound to every instance of the top.
// Assumes: only top-level ports are observed.
module kdf_stage_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lc_disable,
    input logic [2:0] stage,
    input logic [1:0] status,
    input logic       cfg_wen,
    input logic [2:0] hash_cmd,
    input logic       op_done,
    input logic       err_irq,
    input logic       bind_wen,
    input logic       alert_fatal
);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (op_done && status == 2'd3));

    p_cmd_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hash_cmd));

    p_cfg_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd1) |-> (!cfg_wen && hash_cmd != 3'd0));

    p_bind_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stage != $past(stage) && stage >= 3'd1 && stage <= 3'd3) |-> !bind_wen);

    p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lc_disable |=> (stage == 3'd4 || stage == 3'd5));

    p_fatal_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alert_fatal |=> alert_fatal);

    p_invalid_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 3'd5) |=> (stage == 3'd5));

endmodule

bind kdf_stage_ctrl kdf_stage_ctrl_chk u_kdf_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lc_disable  (lc_disable),
    .stage       (stage),
    .status      (status),
    .cfg_wen     (cfg_wen),
    .hash_cmd    (hash_cmd),
    .op_done     (op_done),
    .err_irq     (err_irq),
    .bind_wen    (bind_wen),
    .alert_fatal (alert_fatal)
);

// File: tb/kdf_stage_ctrl_bench.sv
`timescale 1ns/1ps
module kdf_stage_ctrl_bench;

    localparam int VER_W  = 16;
    localparam int DATA_W = 32;
    localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [2:0]        op_en;
    logic [VER_W-1:0]  key_ver;
    logic [VER_W-1:0]  max_ver;
    logic [DATA_W-1:0] in_data;
    logic              lc_disable;
    logic              dis_req;
    logic              bind_unlock;
    logic              hash_done;
    logic [2:0]        hash_cmd;
    logic              hash_key_ok;
    logic [2:0]        stage;
    logic [1:0]        status;
    logic [1:0]        err_code;
    logic              op_done;
    logic              err_irq;
    logic              alert_recov;
    logic              alert_fatal;
    logic              fault_cmd;
    logic              fault_done;
    logic              cfg_wen;
    logic              bind_wen;
    logic              sw_out_we;

    int n_chk  = 0;
    int n_fail = 0;
    int m_stage;
    int m_bind;
    bit finished = 0;

    always #2 clk = ~clk;

    kdf_stage_ctrl #(.VER_W(VER_W), .DATA_W(DATA_W)) u_kdf_stage_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op_en(op_en),
        .key_ver(key_ver), .max_ver(max_ver), .in_data(in_data),
        .lc_disable(lc_disable), .dis_req(dis_req), .bind_unlock(bind_unlock),
        .hash_done(hash_done), .hash_cmd(hash_cmd), .hash_key_ok(hash_key_ok),
        .stage(stage), .status(status), .err_code(err_code), .op_done(op_done),
        .err_irq(err_irq), .alert_recov(alert_recov), .alert_fatal(alert_fatal),
        .fault_cmd(fault_cmd), .fault_done(fault_done), .cfg_wen(cfg_wen),
        .bind_wen(bind_wen), .sw_out_we(sw_out_we)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected error code from the requirement rules (R2..R5).
    function automatic int exp_code(int stg, logic [2:0] op, logic [VER_W-1:0] kv,
                                    logic [VER_W-1:0] mv, logic [DATA_W-1:0] d);
        bit legal;
        legal = op[0] ? (stg <= 3) : (stg >= 1 && stg <= 3);
        if (!legal) return 1;
        if (!op[0] && kv > mv) return 2;
        if (d == '0 || d == ONES) return 3;
        return 0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 0; op_en = 0; key_ver = 0; max_ver = 0; in_data = 32'h5a5a_1234;
        lc_disable = 0; dis_req = 0; bind_unlock = 0; hash_done = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_stage = 0; m_bind = 1;
        @(negedge clk);
    endtask

    task automatic check_reset();
        chk("R1", "stage", stage, 0);
        chk("R1", "status", status, 0);
        chk("R1", "err_code", err_code, 0);
        chk("R1", "cfg_wen", cfg_wen, 1);
        chk("R1", "bind_wen", bind_wen, 1);
        chk("R1", "hash_cmd", hash_cmd, 0);
        chk("R1", "alert_fatal", alert_fatal, 0);
        chk("R1", "op_done", op_done, 0);
    endtask

    // One complete operation with a hash latency of lat cycles, checked against the model.
    task automatic run_op(input logic [2:0] op, input logic [VER_W-1:0] kv,
                          input logic [VER_W-1:0] mv, input logic [DATA_W-1:0] d,
                          input int lat, input bit poke_start);
        int code;
        code = exp_code(m_stage, op, kv, mv, d);
        start = 1; op_en = op; key_ver = kv; max_ver = mv; in_data = d;
        @(negedge clk);
        start = 0;
        chk("R7", "status running", status, 1);
        chk("R7", "cfg_wen running", cfg_wen, 0);
        chk("R7", "hash_cmd", hash_cmd, op);
        chk("R4", "hash_key_ok", hash_key_ok, code == 0);
        if (poke_start) begin
            start = 1;
            @(negedge clk);
            start = 0;
            chk("R7", "start ignored", status, 1);
        end
        repeat (lat - 1) @(negedge clk);
        hash_done = 1;
        @(negedge clk);
        hash_done = 0;
        if (code == 0 && op[0]) begin
            m_stage = (m_stage == 3) ? 4 : m_stage + 1;
            m_bind = 0;
        end
        chk("R6", "op_done", op_done, 1);
        chk("R6", "status done", status, code == 0 ? 2 : 3);
        chk("R5", "err_code", err_code, code);
        chk("R6", "err_irq", err_irq, code != 0);
        chk("R6", "alert_recov", alert_recov, code != 0);
        chk("R3", "sw_out_we", sw_out_we, code == 0 && op[2]);
        chk("R2", "stage", stage, m_stage);
        chk("R8", "bind_wen", bind_wen, m_bind);
        @(negedge clk);
        chk("R6", "op_done pulse width", op_done, 0);
        chk("R7", "hash_cmd idle", hash_cmd, 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        do_reset();
        check_reset();

        // Generate in the reset stage is illegal (R3).
        run_op(3'b010, 1, 5, 32'h1111_2222, 2, 0);
        // Climb to creator; binding enable closes then reopens (R2, R8).
        run_op(3'b001, 0, 0, 32'hcafe_0001, 1, 0);
        bind_unlock = 1; @(negedge clk); bind_unlock = 0;
        m_bind = 1;
        chk("R8", "bind_wen reopened", bind_wen, 1);
        // Version above maximum (R4), data all ones (R5), success with start poke (R7).
        run_op(3'b100, 9, 4, 32'h0bad_f00d, 3, 0);
        chk("R4", "stage unchanged", stage, 1);
        run_op(3'b010, 2, 4, ONES, 2, 0);
        run_op(3'b010, 2, 2, '0, 1, 0);
        run_op(3'b100, 4, 4, 32'h1357_9bdf, 3, 1);

        // Disable mid-run (R9).
        start = 1; op_en = 3'b001; in_data = 32'h2468_ace0;
        @(negedge clk);
        start = 0;
        chk("R9", "key ok before disable", hash_key_ok, 1);
        lc_disable = 1; #1;
        chk("R9", "key wiped at once", hash_key_ok, 0);
        @(negedge clk);
        lc_disable = 0;
        chk("R9", "stage disabled", stage, 4);
        m_stage = 4;
        hash_done = 1; @(negedge clk); hash_done = 0;
        chk("R9", "aborted status", status, 3);
        chk("R9", "aborted code", err_code, 1);
        run_op(3'b100, 0, 1, 32'h0000_0042, 2, 0);
        run_op(3'b001, 0, 1, 32'h0000_0042, 1, 0);

        // Random sequences (R2..R6).
        do_reset();
        for (int i = 0; i < 80; i++) begin
            logic [2:0] op;
            logic [DATA_W-1:0] d;
            int r;
            r = $urandom % 8;
            op = 3'b001 << ($urandom % 3);
            d = (r == 0) ? '0 : (r == 1) ? ONES : $urandom;
            run_op(op, VER_W'($urandom % 8), VER_W'($urandom % 8), d, 1 + $urandom % 4, 0);
            if ($urandom % 4 == 0) begin
                bind_unlock = 1; @(negedge clk); bind_unlock = 0; m_bind = 1;
            end
            if (m_stage == 4) begin
                do_reset();
                check_reset();
            end
        end

        // Direct disable from reset stage (R9).
        do_reset();
        dis_req = 1; @(negedge clk); dis_req = 0;
        chk("R9", "direct disable", stage, 4);

        // Stray completion (R11), then failing operations (R12).
        do_reset();
        hash_done = 1; @(negedge clk); hash_done = 0;
        chk("R11", "fault_done", fault_done, 1);
        chk("R11", "alert_fatal", alert_fatal, 1);
        chk("R11", "stage invalid", stage, 5);
        m_stage = 5;
        run_op(3'b001, 0, 0, 32'h1234_5678, 2, 0);
        run_op(3'b010, 0, 3, 32'h1234_5678, 1, 0);
        chk("R12", "stage stays invalid", stage, 5);

        // Non-one-hot start (R10).
        do_reset();
        start = 1; op_en = 3'b011; @(negedge clk); start = 0; op_en = 0;
        chk("R10", "fault_cmd", fault_cmd, 1);
        chk("R10", "stage invalid", stage, 5);
        chk("R10", "no run", status, 0);

        // Command change during a run (R10, R12).
        do_reset();
        start = 1; op_en = 3'b001; in_data = 32'h7777_0001;
        @(negedge clk);
        start = 0; op_en = 3'b100;
        @(negedge clk);
        op_en = 3'b001;
        chk("R10", "fault_cmd flip", fault_cmd, 1);
        chk("R10", "stage invalid flip", stage, 5);
        hash_done = 1; @(negedge clk); hash_done = 0;
        chk("R12", "flip run fails", status, 3);
        chk("R12", "flip code", err_code, 1);
        @(negedge clk);
        chk("R10", "alert sticky", alert_fatal, 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule